// File: doc/BRIEF.md
# Background Calibration Conversion Sequencer

This block is the cycle-level controller of a delta-sigma converter. A strobe marks the start of every conversion cycle. On each strobe the sequencer classifies the new cycle and registers three things: which signal the sampling capacitor sees (the analog input, a short, or the reference), whether an offset or gain calibration starts in that cycle, and whether the cycle delivers valid data through an active-low data-ready output. The modulator, the filter arithmetic and the serial shifter sit outside this block. They only consume the sequencer's outputs.

In background calibration mode, calibration runs alongside normal conversion in a repeating six-cycle pattern. The valid-data cycle shorts the input and starts an offset calibration. Three reference cycles carry a gain calibration. Two further analog conversions refill the filter. Any other non-sleep mode code gives a plain normal mode, in which every cycle is valid data.

A sleep code parks the converter and cuts serial access. Access comes back through one of three wake events. A later mode write then starts a power-up delay, followed by a settling conversion, with data-ready held high across the first two cycles after wake.

Top module: `adc_bgcal_seq`

## Requirements
- R1: When the synchronous reset `rst` is high, the block enters normal mode and sets its outputs as follows: `drdy_n`=1, `in_sel`=0, no calibration pulse, and `ser_en`=1.
- R2: In normal mode (any mode code other than 3'b001 and 3'b110), every conversion strobe registers a cycle with `drdy_n`=0 and `in_sel`=0 (analog input) on the clock edge that samples the strobe.
- R3: The valid-data cycle in background mode (mode code 3'b001) registers `drdy_n`=0, `in_sel`=1 (shorted input) and a one-clock `ofs_cal_go` pulse.
- R4: In background mode, the three cycles after the valid-data cycle register `in_sel`=2 (reference) with `drdy_n`=1. The first of these three cycles carries a one-clock `gain_cal_go` pulse.
- R5: After the three reference cycles, two analog cycles (`in_sel`=0, `drdy_n`=1) follow. The pattern then repeats, so `drdy_n` goes low once every six strobes.
- R6: Writing the background code while the block runs in another mode makes the next strobe the first gain cycle, so the first valid-data cycle comes on the sixth strobe.
- R7: Between strobes, `drdy_n` and `in_sel` hold their values. Both calibration pulses last exactly one clock.
- R8: Writing 3'b110 while running enters sleep on the next clock edge. In sleep, `drdy_n`=1, `in_sel`=0, `ser_en`=0, and strobes have no effect.
- R9: With `cfg_cs_used`=1, a low `cs_n` in sleep sets `ser_en` again.
- R10: With `cfg_cs_used`=0 and `cfg_slave`=0, `ser_en` is restored by a falling edge of `sdio`, but only after `sdio` has been high for at least 4 clocks. A shorter high period clears the count and does not wake the block.
- R11: With `cfg_cs_used`=0 and `cfg_slave`=1, an `instr_rx` pulse in sleep sets `ser_en` again.
- R12: The following mode writes are ignored: writes in sleep while `ser_en`=0, and writes during the wake sequence. Sleep continues and `drdy_n` stays 1.
- R13: A non-sleep write in sleep with `ser_en`=1 starts the wake sequence:
  - The block waits PWRUP_CLKS clocks and ignores strobes during that time.
  - The first strobe after the wait is an analog cycle with `drdy_n`=1.
  - The second strobe starts the new mode with `drdy_n`=1. For background mode this is the gain cycle of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_tick | input | 1 | One-clock strobe marking the start of a conversion cycle |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_val | input | 3 | Operation mode code (3'b110 sleep, 3'b001 background, others normal) |
| cfg_cs_used | input | 1 | 1 when chip select is wired and used for wake |
| cfg_slave | input | 1 | 1 for slave serial mode, 0 for master |
| cs_n | input | 1 | Chip select, active low |
| sdio | input | 1 | Serial data line level |
| instr_rx | input | 1 | Pulse when the serial port receives an instruction |
| in_sel | output | 2 | Sampling input select: 0 analog, 1 shorted, 2 reference |
| ofs_cal_go | output | 1 | One-clock offset calibration start |
| gain_cal_go | output | 1 | One-clock gain calibration start |
| drdy_n | output | 1 | Data ready, active low |
| ser_en | output | 1 | Serial access enabled |

## Verification
The bench checks the following corner cases and the failure each would expose:

- **Entry phase.** It checks where the six-cycle pattern starts when background mode is entered. A sequencer that began at the valid-data cycle would raise `drdy_n` low on the first strobe, which is before any gain calibration.
- **Wake threshold.** It drives the data-line wake with exactly three and then exactly four high clocks. An off-by-one in the counter would wake early or never.
- **Writes while asleep.** It issues a mode write while serial access is still cut off. A design that accepted it would leave sleep with no wake event.
- **Wake sequence.** It counts the strobes after a wake into both normal and background modes. A design that skipped the settling conversion, or let a strobe through during power-up, would drop `drdy_n` one or more cycles too early.

// File: rtl/adc_bgcal_pkg.sv
package adc_bgcal_pkg;

   typedef enum logic [1:0] {
      SEL_AIN   = 2'd0,
      SEL_SHORT = 2'd1,
      SEL_REF   = 2'd2
   } insel_e;

   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_SLEEP = 3'd1,
      ST_PWRUP = 3'd2,
      ST_WAIT1 = 3'd3,
      ST_WAIT2 = 3'd4
   } seq_st_e;

endpackage

// File: rtl/bgcal_wake_det.sv
module bgcal_wake_det #(
   parameter int WAKE_HI = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic asleep,
   input  logic go_sleep,
   input  logic cfg_cs_used,
   input  logic cfg_slave,
   input  logic cs_n,
   input  logic sdio,
   input  logic instr_rx,
   output logic ser_en
);
   localparam int CW = $clog2(WAKE_HI + 1);

   logic [CW-1:0] hi_cnt;
   logic          sdio_q;
   logic          line_wake;
   logic          wake_evt;

   initial assert (WAKE_HI >= 1) else $error("WAKE_HI must be at least 1");

   // Count clocks with the data line high; saturate at the threshold
   always_ff @(posedge clk) begin
      if (rst) begin
         hi_cnt <= '0;
         sdio_q <= 1'b0;
      end else begin
         sdio_q <= sdio;
         if (!sdio)
            hi_cnt <= '0;
         else if (hi_cnt != CW'(WAKE_HI))
            hi_cnt <= hi_cnt + 1'b1;
      end
   end

   assign line_wake = sdio_q && !sdio && (hi_cnt == CW'(WAKE_HI));

   always_comb begin
      if (cfg_cs_used)
         wake_evt = !cs_n;
      else if (cfg_slave)
         wake_evt = instr_rx;
      else
         wake_evt = line_wake;
   end

   always_ff @(posedge clk) begin
      if (rst)
         ser_en <= 1'b1;
      else if (go_sleep)
         ser_en <= 1'b0;
      else if (asleep && !ser_en && wake_evt)
         ser_en <= 1'b1;
   end

   // R8: serial access is cut on entry to sleep
   p_ser_cut_r8: assert property (@(posedge clk) disable iff (rst)
      $past(go_sleep) |-> !ser_en);

   // R10: a data-line wake only follows a full high period
   p_line_wake_r10: assert property (@(posedge clk) disable iff (rst)
      ($rose(ser_en) && !cfg_cs_used && !cfg_slave) |-> ($past(hi_cnt) == CW'(WAKE_HI)));

endmodule

// File: rtl/bgcal_phase_gen.sv
module bgcal_phase_gen #(
   parameter int CYC_LEN = 6,
   parameter int REF_CYC = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic adv,
   output logic ph_valid,
   output logic ph_ref,
   output logic ph_gain_start
);
   localparam int PW = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;

   logic [PW-1:0] phase;
   logic [PW-1:0] phase_nx;

   initial assert (REF_CYC >= 1 && REF_CYC + 2 <= CYC_LEN)
      else $error("pattern needs one valid, REF_CYC reference and at least one fill cycle");

   generate
      if ((CYC_LEN & (CYC_LEN - 1)) == 0) begin : g_pow2
         assign phase_nx = phase + 1'b1;
      end else begin : g_cmp
         assign phase_nx = (phase == PW'(CYC_LEN - 1)) ? '0 : phase + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         phase <= '0;
      else if (load)
         phase <= PW'(1);
      else if (adv)
         phase <= phase_nx;
   end

   assign ph_valid      = (phase == '0);
   assign ph_ref        = (phase != '0) && (phase <= PW'(REF_CYC));
   assign ph_gain_start = (phase == PW'(1));

   // R5: phase stays inside the pattern
   p_phase_range_r5: assert property (@(posedge clk) disable iff (rst)
      phase < PW'(CYC_LEN));

endmodule

// File: rtl/bgcal_mode_ctl.sv
module bgcal_mode_ctl
   import adc_bgcal_pkg::*;
#(
   parameter int                MODE_W     = 3,
   parameter logic [MODE_W-1:0] SLEEP_CODE = 3'b110,
   parameter logic [MODE_W-1:0] BKG_CODE   = 3'b001,
   parameter int                PWRUP_CLKS = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_val,
   input  logic              ser_en,
   output seq_st_e           st,
   output logic              bkg_on,
   output logic              go_sleep,
   output logic              load_ph
);
   localparam int PCW = $clog2(PWRUP_CLKS + 1);

   logic [PCW-1:0] pw_cnt;
   logic           acc;
   logic           is_sleep;
   logic           is_bkg;

   initial assert (PWRUP_CLKS >= 1) else $error("PWRUP_CLKS must be at least 1");
   initial assert (SLEEP_CODE != BKG_CODE) else $error("mode codes collide");

   assign is_sleep = (mode_val == SLEEP_CODE);
   assign is_bkg   = (mode_val == BKG_CODE);
   assign acc      = mode_wr && ((st == ST_RUN) || ((st == ST_SLEEP) && ser_en));
   assign go_sleep = acc && (st == ST_RUN) && is_sleep;

   always_comb begin
      load_ph = 1'b0;
      if (acc && is_bkg) begin
         if (st == ST_RUN)
            load_ph = !bkg_on;
         else
            load_ph = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= ST_RUN;
         bkg_on <= 1'b0;
         pw_cnt <= '0;
      end else begin
         case (st)
            ST_RUN: begin
               if (go_sleep)
                  st <= ST_SLEEP;
               else if (acc)
                  bkg_on <= is_bkg;
            end
            ST_SLEEP: begin
               if (acc && !is_sleep) begin
                  bkg_on <= is_bkg;
                  pw_cnt <= '0;
                  st     <= ST_PWRUP;
               end
            end
            ST_PWRUP: begin
               if (pw_cnt == PCW'(PWRUP_CLKS - 1))
                  st <= ST_WAIT1;
               else
                  pw_cnt <= pw_cnt + 1'b1;
            end
            ST_WAIT1: if (tick) st <= ST_WAIT2;
            ST_WAIT2: if (tick) st <= ST_RUN;
            default:  st <= ST_RUN;
         endcase
      end
   end

   // R12: without serial access, sleep cannot be left
   p_sleep_locked_r12: assert property (@(posedge clk) disable iff (rst)
      (st == ST_SLEEP && !ser_en) |=> (st == ST_SLEEP));

   // R13: the wake sequence moves forward only
   p_wake_order_r13: assert property (@(posedge clk) disable iff (rst)
      (st == ST_WAIT1) |=> (st == ST_WAIT1 || st == ST_WAIT2));

endmodule

// File: rtl/adc_bgcal_seq.sv
module adc_bgcal_seq
   import adc_bgcal_pkg::*;
#(
   parameter int           MODE_W     = 3,
   parameter logic [2:0]   SLEEP_CODE = 3'b110,
   parameter logic [2:0]   BKG_CODE   = 3'b001,
   parameter int           CYC_LEN    = 6,
   parameter int           REF_CYC    = 3,
   parameter int           WAKE_HI    = 4,
   parameter int           PWRUP_CLKS = 8
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        conv_tick,
   input  logic        mode_wr,
   input  logic [2:0]  mode_val,
   input  logic        cfg_cs_used,
   input  logic        cfg_slave,
   input  logic        cs_n,
   input  logic        sdio,
   input  logic        instr_rx,
   output logic [1:0]  in_sel,
   output logic        ofs_cal_go,
   output logic        gain_cal_go,
   output logic        drdy_n,
   output logic        ser_en
);
   seq_st_e st;
   logic    bkg_on, go_sleep, load_ph, adv;
   logic    ph_valid, ph_ref, ph_gain_start;
   logic    emit_run;
   logic    asleep;

   initial assert (MODE_W == 3) else $error("mode field is three bits wide");

   bgcal_mode_ctl #(
      .MODE_W(MODE_W), .SLEEP_CODE(SLEEP_CODE), .BKG_CODE(BKG_CODE),
      .PWRUP_CLKS(PWRUP_CLKS)
   ) u_ctl (
      .clk(clk), .rst(rst), .tick(conv_tick), .mode_wr(mode_wr),
      .mode_val(mode_val), .ser_en(ser_en), .st(st), .bkg_on(bkg_on),
      .go_sleep(go_sleep), .load_ph(load_ph)
   );

   bgcal_phase_gen #(.CYC_LEN(CYC_LEN), .REF_CYC(REF_CYC)) u_ph (
      .clk(clk), .rst(rst), .load(load_ph), .adv(adv),
      .ph_valid(ph_valid), .ph_ref(ph_ref), .ph_gain_start(ph_gain_start)
   );

   assign asleep = (st == ST_SLEEP);

   bgcal_wake_det #(.WAKE_HI(WAKE_HI)) u_wake (
      .clk(clk), .rst(rst), .asleep(asleep), .go_sleep(go_sleep),
      .cfg_cs_used(cfg_cs_used), .cfg_slave(cfg_slave), .cs_n(cs_n),
      .sdio(sdio), .instr_rx(instr_rx), .ser_en(ser_en)
   );

   assign emit_run = conv_tick && !go_sleep && ((st == ST_RUN) || (st == ST_WAIT2));
   assign adv      = emit_run && bkg_on;

   always_ff @(posedge clk) begin
      if (rst) begin
         drdy_n      <= 1'b1;
         in_sel      <= SEL_AIN;
         ofs_cal_go  <= 1'b0;
         gain_cal_go <= 1'b0;
      end else begin
         ofs_cal_go  <= 1'b0;
         gain_cal_go <= 1'b0;
         if (go_sleep) begin
            drdy_n <= 1'b1;
            in_sel <= SEL_AIN;
         end else if (emit_run && bkg_on) begin
            drdy_n      <= !ph_valid;
            in_sel      <= ph_valid ? SEL_SHORT : (ph_ref ? SEL_REF : SEL_AIN);
            ofs_cal_go  <= ph_valid;
            gain_cal_go <= ph_gain_start;
         end else if (emit_run) begin
            drdy_n <= (st == ST_WAIT2);
            in_sel <= SEL_AIN;
         end else if (conv_tick && st == ST_WAIT1) begin
            drdy_n <= 1'b1;
            in_sel <= SEL_AIN;
         end
      end
   end

   // R3: offset start only in the shorted valid-data cycle
   p_ofs_short_r3: assert property (@(posedge clk) disable iff (rst)
      ofs_cal_go |-> (!drdy_n && in_sel == SEL_SHORT));

   // R4: gain start only with the reference connected and no data
   p_gain_ref_r4: assert property (@(posedge clk) disable iff (rst)
      gain_cal_go |-> (drdy_n && in_sel == SEL_REF));

   // R7: pulses are one clock wide
   p_ofs_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      ofs_cal_go |=> !ofs_cal_go);
   p_gain_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      gain_cal_go |=> !gain_cal_go);

   // R7: no change between strobes
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!$past(conv_tick) && !$past(go_sleep) && !$past(rst)) |-> ($stable(drdy_n) && $stable(in_sel)));

   // R8: sleep and power-up are quiet
   p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      (st == ST_SLEEP || st == ST_PWRUP) |-> (drdy_n && !ofs_cal_go && !gain_cal_go));

   // R13: no valid data while settling
   p_settle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
      (st == ST_WAIT1 || st == ST_WAIT2) |-> drdy_n);

endmodule

// File: tb/adc_bgcal_seq_tb.sv
module adc_bgcal_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int PWR = 8;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       conv_tick = 1'b0, mode_wr = 1'b0;
   logic [2:0] mode_val = 3'd0;
   logic       cfg_cs_used = 1'b1, cfg_slave = 1'b0, cs_n = 1'b1, sdio = 1'b0, instr_rx = 1'b0;
   logic [1:0] in_sel;
   logic       ofs_cal_go, gain_cal_go, drdy_n, ser_en;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit cmp_on = 1'b0;
   string cur_req = "R1";

   // reference model state
   int m_st, m_ph, m_pw, m_hi;
   bit m_bkg, m_prev, m_ser;
   bit e_drdy, e_ofs, e_gain;
   int e_sel;

   logic [1:0] c_sel;
   logic c_drdy, c_ofs, c_gain;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_bgcal_seq dut_i (
      .clk(clk), .rst(rst), .conv_tick(conv_tick), .mode_wr(mode_wr), .mode_val(mode_val),
      .cfg_cs_used(cfg_cs_used), .cfg_slave(cfg_slave), .cs_n(cs_n), .sdio(sdio),
      .instr_rx(instr_rx), .in_sel(in_sel), .ofs_cal_go(ofs_cal_go),
      .gain_cal_go(gain_cal_go), .drdy_n(drdy_n), .ser_en(ser_en)
   );

   task automatic emit(input int ph);
      e_drdy = (ph != 0);
      e_sel  = (ph == 0) ? 1 : ((ph <= 3) ? 2 : 0);
      e_ofs  = (ph == 0);
      e_gain = (ph == 1);
   endtask

   always @(posedge clk) begin
      bit acc, gs, wake;
      int ost;
      if (rst) begin
         m_st = 0; m_ph = 0; m_pw = 0; m_hi = 0; m_bkg = 0; m_prev = 0; m_ser = 1;
         e_drdy = 1; e_sel = 0; e_ofs = 0; e_gain = 0;
      end else begin
         ost = m_st;
         acc = mode_wr && (ost == 0 || (ost == 1 && m_ser));
         gs  = acc && ost == 0 && mode_val == 3'b110;
         e_ofs = 0; e_gain = 0;
         if (gs) begin
            e_drdy = 1; e_sel = 0;
         end else if (conv_tick && (ost == 0 || ost == 4)) begin
            if (m_bkg) begin emit(m_ph); m_ph = (m_ph + 1) % 6; end
            else begin e_drdy = (ost == 4); e_sel = 0; end
         end else if (conv_tick && ost == 3) begin
            e_drdy = 1; e_sel = 0;
         end
         if (cfg_cs_used) wake = !cs_n;
         else if (cfg_slave) wake = instr_rx;
         else wake = m_prev && !sdio && (m_hi >= 4);
         if (gs) m_ser = 0;
         else if (ost == 1 && !m_ser && wake) m_ser = 1;
         m_hi = sdio ? ((m_hi < 4) ? m_hi + 1 : 4) : 0;
         m_prev = sdio;
         case (ost)
            0: if (gs) m_st = 1;
               else if (acc) begin
                  if (mode_val == 3'b001 && !m_bkg) m_ph = 1;
                  m_bkg = (mode_val == 3'b001);
               end
            1: if (acc && mode_val != 3'b110) begin
                  m_bkg = (mode_val == 3'b001);
                  if (m_bkg) m_ph = 1;
                  m_pw = 0; m_st = 2;
               end
            2: if (m_pw == PWR - 1) m_st = 3; else m_pw++;
            3: if (conv_tick) m_st = 4;
            4: if (conv_tick) m_st = 0;
            default: ;
         endcase
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (cmp_on) begin
         n_chk++;
         if (drdy_n !== e_drdy || in_sel !== 2'(e_sel) || ofs_cal_go !== e_ofs ||
             gain_cal_go !== e_gain || ser_en !== m_ser) begin
            n_bad++;
            $display("FAIL %s cycle %0d: drdy_n=%0b sel=%0d ofs=%0b gain=%0b ser=%0b exp %0b %0d %0b %0b %0b",
                     cur_req, cyc, drdy_n, in_sel, ofs_cal_go, gain_cal_go, ser_en,
                     e_drdy, e_sel, e_ofs, e_gain, m_ser);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_bad++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_tick();
      @(negedge clk) conv_tick = 1'b1;
      @(negedge clk) conv_tick = 1'b0;
      c_sel = in_sel; c_drdy = drdy_n; c_ofs = ofs_cal_go; c_gain = gain_cal_go;
      repeat (3) @(negedge clk);
   endtask

   task automatic wr_mode(input logic [2:0] v);
      @(negedge clk) begin mode_wr = 1'b1; mode_val = v; end
      @(negedge clk) mode_wr = 1'b0;
   endtask

   initial begin
      int lows;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      cmp_on = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk("R1 drdy_n", drdy_n, 1); chk("R1 in_sel", in_sel, 0); chk("R1 ser_en", ser_en, 1);
      chk("R1 pulses", ofs_cal_go | gain_cal_go, 0);

      cur_req = "R2";
      do_tick(); chk("R2 drdy_n", c_drdy, 0); chk("R2 in_sel", c_sel, 0);
      do_tick(); chk("R2 drdy_n again", c_drdy, 0);

      cur_req = "R6";
      wr_mode(3'b001);
      do_tick(); chk("R6 gain pulse first", c_gain, 1); chk("R6 ref first", c_sel, 2);
      chk("R6 drdy_n", c_drdy, 1);
      cur_req = "R4";
      do_tick(); chk("R4 ref 2nd", c_sel, 2); chk("R4 no gain 2nd", c_gain, 0);
      do_tick(); chk("R4 ref 3rd", c_sel, 2);
      cur_req = "R5";
      do_tick(); chk("R5 fill sel", c_sel, 0); chk("R5 fill drdy", c_drdy, 1);
      do_tick(); chk("R5 fill2 drdy", c_drdy, 1);
      cur_req = "R3";
      do_tick(); chk("R3 drdy_n", c_drdy, 0); chk("R3 short", c_sel, 1); chk("R3 ofs", c_ofs, 1);
      chk("R7 ofs dropped", ofs_cal_go, 0); chk("R7 drdy held", drdy_n, 0);
      cur_req = "R5";
      lows = 0;
      for (int i = 0; i < 12; i++) begin do_tick(); if (c_drdy == 1'b0) lows++; end
      chk("R5 valid per 12 strobes", lows, 2);

      cur_req = "R2";
      wr_mode(3'b010);
      do_tick(); chk("R2 after leaving bkg", c_drdy, 0);

      cur_req = "R8";
      wr_mode(3'b110);
      chk("R8 ser_en off", ser_en, 0); chk("R8 drdy_n", drdy_n, 1);
      do_tick(); chk("R8 strobe ignored", c_drdy, 1); chk("R8 no pulse", c_ofs | c_gain, 0);
      cur_req = "R12";
      wr_mode(3'b000);
      repeat (PWR + 2) @(negedge clk);
      do_tick(); do_tick();
      chk("R12 still asleep drdy", c_drdy, 1); chk("R12 ser_en", ser_en, 0);
      cur_req = "R9";
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk) cs_n = 1'b1;
      chk("R9 cs wake", ser_en, 1);
      cur_req = "R13";
      wr_mode(3'b001);
      do_tick(); chk("R13 strobe in power-up ignored", c_drdy, 1);
      repeat (PWR) @(negedge clk);
      do_tick(); chk("R13 first drdy", c_drdy, 1); chk("R13 first sel", c_sel, 0);
      chk("R13 first no gain", c_gain, 0);
      do_tick(); chk("R13 bkg gain", c_gain, 1); chk("R13 bkg ref", c_sel, 2);
      for (int i = 0; i < 5; i++) do_tick();
      chk("R13 bkg first valid", c_drdy, 0);

      cur_req = "R10";
      cfg_cs_used = 1'b0; cfg_slave = 1'b0;
      wr_mode(3'b110);
      @(negedge clk) sdio = 1'b1;
      repeat (3) @(negedge clk);
      sdio = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 three high clocks no wake", ser_en, 0);
      sdio = 1'b1;
      repeat (4) @(negedge clk);
      sdio = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 four high clocks wake", ser_en, 1);
      cur_req = "R13";
      wr_mode(3'b000);
      repeat (PWR + 1) @(negedge clk);
      do_tick(); chk("R13 normal 1st drdy", c_drdy, 1);
      do_tick(); chk("R13 normal 2nd drdy", c_drdy, 1);
      do_tick(); chk("R13 normal 3rd drdy", c_drdy, 0);

      cur_req = "R11";
      cfg_slave = 1'b1;
      wr_mode(3'b110);
      @(negedge clk) instr_rx = 1'b1;
      @(negedge clk) instr_rx = 1'b0;
      chk("R11 slave wake", ser_en, 1);
      wr_mode(3'b001);
      repeat (PWR + 1) @(negedge clk);
      for (int i = 0; i < 8; i++) do_tick();

      cmp_on = 1'b0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule